// File: doc/BRIEF.md
# PWM Time-Base Counter

This block is the timing spine of one PWM channel. A 16-bit counter advances once per prescaled tick and runs in one of four styles: counting up and wrapping, counting down and reloading, counting up then down in a triangle, or holding its value. The tick comes from two cascaded dividers. One divides by a power of two. The other divides by one or by an even number up to fourteen. Their product sets the tick period.

Software reaches the block through a one-cycle write port with four addresses: a control word, the period, the phase and a flag-clear word. The period has a shadow copy. It is promoted to the active period when the count reaches zero, or it is copied at once, depending on a control bit. A sync event can load the phase value into the counter and pick the direction of a triangle count. A sync event comes from the sync input or from a one-shot force bit in the control word. The block drives a sync output whose source can be chosen, zero and period strobes qualified by the tick, a direction bit, and two sticky flags. Downstream compare and action logic uses these outputs.

Top module: `pwm_timebase`

## Requirements
- R1: After reset, the count is 0, the direction bit is 1, both sticky flags are 0, the sync output is 0, and the counter is held.
- R2: The control word (address 0) carries the following fields. Bits [1:0] select the mode (0 up, 1 down, 2 up-down, 3 hold). Bit 2 enables phase loading. Bit 3 selects direct period writes. Bits [5:4] select the sync-out source. Bit 6 is the sync force. Bits [9:7] hold the second-stage code h. Bits [12:10] hold the first-stage code d. Bit 13 sets the direction after a phase load. The tick period is 2^d times (h=0 ? 1 : 2h) clock cycles.
- R3: In up mode, each tick adds one to the count. A tick taken at a count at or above the active period sets the count to 0. The direction bit reads 1.
- R4: In down mode, each tick subtracts one from the count. A tick taken at count 0 loads the active period. The direction bit reads 0.
- R5: In up-down mode, the count rises until it reaches the active period and then falls to 0. The direction bit changes on the tick that leaves each end.
- R6: In hold mode (mode 3), the count does not change when ticks arrive.
- R7: When phase loading is enabled, a pulse on the sync input loads the phase register (address 2) into the count two clock edges later. In up-down mode, the direction then follows control bit 13. When phase loading is disabled, the pulse leaves the count unchanged.
- R8: Writing the control word with bit 6 set causes exactly one sync event. The bit is not retained, so the counter moves on from the loaded phase at the next tick.
- R9: The sync-out source is chosen by code. Code 0 gives the sync input delayed by one clock. Code 1 gives the zero strobe. Code 2 pulses on a tick when the count equals the compare-B input. Code 3 holds the output at 0.
- R10: With bit 3 clear, a period write (address 1) becomes active on the tick taken at count 0. With bit 3 set, it becomes active within two clocks.
- R11: The zero and period strobes are high only while the tick enable is high, and only when the count equals 0 or the active period.
- R12: The sync-seen flag sets on a sync-input pulse but not on a force. The max flag sets while the count is 0xFFFF. Both flags stay set until a write to address 3 with bit 0 (sync-seen) or bit 1 (max) set clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address: 0 control, 1 period, 2 phase, 3 flag clear |
| wrData | input | 16 | Register write data |
| syncIn | input | 1 | Sync input pulse |
| cmpB | input | 16 | Compare-B value for the sync-out source |
| count | output | 16 | Current count |
| dirUp | output | 1 | Count direction, 1 when counting up |
| tickEn | output | 1 | Prescaled tick enable |
| ctrZero | output | 1 | Tick-qualified count-equals-zero strobe |
| ctrPeriod | output | 1 | Tick-qualified count-equals-period strobe |
| syncOut | output | 1 | Selected sync output |
| syncSeen | output | 1 | Sticky sync-input flag |
| maxSeen | output | 1 | Sticky count-reached-0xFFFF flag |

## Verification
The bench sweeps all 64 divider code pairs and measures the tick spacing. A wrong even-ratio decode would show up as a spacing that is not 2h times 2^d. In each counting style it compares every tick against the arithmetic successor of the previous tick. A triangle that turned one count late, or a down count that wrapped to 0xFFFF, would break that chain. It catches the period being promoted mid-cycle, since the old period would still end the current cycle. It also checks a force bit that is latched instead of pulsed, which would pin the count to the phase value, and flags that clear when the count moves away from 0xFFFF.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

  typedef enum logic [1:0] {
    MODE_UP     = 2'd0,
    MODE_DOWN   = 2'd1,
    MODE_UPDOWN = 2'd2,
    MODE_HOLD   = 2'd3
  } cntMode_e;

  typedef enum logic [1:0] {
    SO_PASS = 2'd0,
    SO_ZERO = 2'd1,
    SO_CMPB = 2'd2,
    SO_OFF  = 2'd3
  } syncSel_e;

  // control word bit positions
  localparam int CTL_MODE_LSB = 0;
  localparam int CTL_PHEN     = 2;
  localparam int CTL_DIRECT   = 3;
  localparam int CTL_SEL_LSB  = 4;
  localparam int CTL_SWF      = 6;
  localparam int CTL_HS_LSB   = 7;
  localparam int CTL_DIV_LSB  = 10;
  localparam int CTL_PHDIR    = 13;

  localparam int ADDR_CTL   = 0;
  localparam int ADDR_PRD   = 1;
  localparam int ADDR_PHASE = 2;
  localparam int ADDR_CLR   = 3;

  typedef struct packed {
    cntMode_e mode;
    logic     phaseEn;
    logic     phaseDir;
    logic     directLoad;
    syncSel_e syncSel;
  } tbCfg_t;

  typedef struct packed {
    logic tick;
    logic syncHw;
    logic syncAny;
    logic prdWr;
    logic clrSync;
    logic clrMax;
  } tbStrobe_t;

endpackage

// File: rtl/tbase_ctrl.sv
module tbase_ctrl
  import tbase_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2,
  parameter int PRE_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              syncIn,
  output tbCfg_t            cfg,
  output tbStrobe_t         strb,
  output logic [CNT_W-1:0]  phaseVal,
  output logic [CNT_W-1:0]  prdShadow
);

  localparam int DIV_W = (1 << PRE_W) + PRE_W;

  logic [PRE_W-1:0] divCode;
  logic [PRE_W-1:0] hsCode;
  logic [DIV_W-1:0] hsMul;
  logic [DIV_W-1:0] divTotal;
  logic [DIV_W-1:0] preCnt;
  logic             tick;
  logic             wrCtl, wrPrd, wrPhase, wrClr;
  logic             syncHwQ, syncAnyQ, prdWrQ, clrSyncQ, clrMaxQ;

  assign wrCtl   = wrEn && (wrAddr == ADDR_W'(ADDR_CTL));
  assign wrPrd   = wrEn && (wrAddr == ADDR_W'(ADDR_PRD));
  assign wrPhase = wrEn && (wrAddr == ADDR_W'(ADDR_PHASE));
  assign wrClr   = wrEn && (wrAddr == ADDR_W'(ADDR_CLR));

  // two-stage ratio: power of two times (1 or even step)
  always_comb begin
    hsMul    = (hsCode == '0) ? DIV_W'(1) : DIV_W'({hsCode, 1'b0});
    divTotal = hsMul << divCode;
  end

  assign tick = (preCnt >= divTotal - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) preCnt <= '0;
    else if (tick) preCnt <= '0;
    else preCnt <= preCnt + DIV_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg       <= '{mode: MODE_HOLD, phaseEn: 1'b0, phaseDir: 1'b0,
                     directLoad: 1'b0, syncSel: SO_PASS};
      divCode   <= '0;
      hsCode    <= '0;
      phaseVal  <= '0;
      prdShadow <= '0;
    end else begin
      if (wrCtl) begin
        cfg.mode       <= cntMode_e'(wrData[CTL_MODE_LSB +: 2]);
        cfg.phaseEn    <= wrData[CTL_PHEN];
        cfg.directLoad <= wrData[CTL_DIRECT];
        cfg.syncSel    <= syncSel_e'(wrData[CTL_SEL_LSB +: 2]);
        cfg.phaseDir   <= wrData[CTL_PHDIR];
        hsCode         <= wrData[CTL_HS_LSB +: PRE_W];
        divCode        <= wrData[CTL_DIV_LSB +: PRE_W];
      end
      if (wrPrd)   prdShadow <= wrData;
      if (wrPhase) phaseVal  <= wrData;
    end
  end

  // event strobes, one clock after their cause
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncHwQ  <= 1'b0;
      syncAnyQ <= 1'b0;
      prdWrQ   <= 1'b0;
      clrSyncQ <= 1'b0;
      clrMaxQ  <= 1'b0;
    end else begin
      syncHwQ  <= syncIn;
      syncAnyQ <= syncIn || (wrCtl && wrData[CTL_SWF]);
      prdWrQ   <= wrPrd;
      clrSyncQ <= wrClr && wrData[0];
      clrMaxQ  <= wrClr && wrData[1];
    end
  end

  always_comb begin
    strb.tick    = tick;
    strb.syncHw  = syncHwQ;
    strb.syncAny = syncAnyQ;
    strb.prdWr   = prdWrQ;
    strb.clrSync = clrSyncQ;
    strb.clrMax  = clrMaxQ;
  end

  // R2: with a ratio above one, two ticks are never back to back
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (tick && divTotal > DIV_W'(1) && !wrCtl) |=> !tick);

  // R8: the force bit gives a single sync event, never a held one
  p_force_once_r8: assert property (@(posedge clk) disable iff (!rstN)
    (syncAnyQ && !syncIn && !wrCtl) |=> !syncAnyQ);

endmodule

// File: rtl/tbase_count.sv
module tbase_count
  import tbase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tbCfg_t           cfg,
  input  tbStrobe_t        strb,
  input  logic [CNT_W-1:0] phaseVal,
  input  logic [CNT_W-1:0] prdShadow,
  input  logic [CNT_W-1:0] cmpB,
  output logic [CNT_W-1:0] count,
  output logic             dirUp,
  output logic             ctrZero,
  output logic             ctrPeriod,
  output logic             syncOut,
  output logic             syncSeen,
  output logic             maxSeen
);

  logic [CNT_W-1:0] actPrd;
  logic [CNT_W-1:0] nxtCnt;
  logic             nxtDir;
  logic             atZero;
  logic             phaseLoad;

  assign atZero    = (count == '0);
  assign ctrZero   = strb.tick && atZero;
  assign ctrPeriod = strb.tick && (count == actPrd);
  assign phaseLoad = strb.syncAny && cfg.phaseEn;

  always_comb begin
    nxtCnt = count;
    nxtDir = dirUp;
    if (phaseLoad) begin
      nxtCnt = phaseVal;
      if (cfg.mode == MODE_UPDOWN) nxtDir = cfg.phaseDir;
    end else if (strb.tick) begin
      unique case (cfg.mode)
        MODE_UP: begin
          nxtDir = 1'b1;
          nxtCnt = (count >= actPrd) ? '0 : count + CNT_W'(1);
        end
        MODE_DOWN: begin
          nxtDir = 1'b0;
          nxtCnt = atZero ? actPrd : count - CNT_W'(1);
        end
        MODE_UPDOWN: begin
          if (actPrd == '0) begin
            nxtCnt = '0;
          end else if (dirUp) begin
            if (count >= actPrd) begin
              nxtDir = 1'b0;
              nxtCnt = count - CNT_W'(1);
            end else begin
              nxtCnt = count + CNT_W'(1);
            end
          end else if (atZero) begin
            nxtDir = 1'b1;
            nxtCnt = count + CNT_W'(1);
          end else begin
            nxtCnt = count - CNT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      dirUp <= 1'b1;
    end else begin
      count <= nxtCnt;
      dirUp <= nxtDir;
    end
  end

  // active period: direct copy or promotion at the zero tick
  always_ff @(posedge clk) begin
    if (!rstN) actPrd <= '0;
    else if (cfg.directLoad) begin
      if (strb.prdWr) actPrd <= prdShadow;
    end else if (ctrZero) begin
      actPrd <= prdShadow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncSeen <= 1'b0;
      maxSeen  <= 1'b0;
    end else begin
      if (strb.syncHw) syncSeen <= 1'b1;
      else if (strb.clrSync) syncSeen <= 1'b0;
      if (count == '1) maxSeen <= 1'b1;
      else if (strb.clrMax) maxSeen <= 1'b0;
    end
  end

  always_comb begin
    unique case (cfg.syncSel)
      SO_PASS: syncOut = strb.syncHw;
      SO_ZERO: syncOut = ctrZero;
      SO_CMPB: syncOut = strb.tick && (count == cmpB);
      default: syncOut = 1'b0;
    endcase
  end

  // R3: up count leaves the top of the period to zero
  p_up_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !phaseLoad && cfg.mode == MODE_UP && count >= actPrd)
    |=> (count == '0));

  // R4: down count at zero reloads the active period
  p_down_reload_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !phaseLoad && cfg.mode == MODE_DOWN && count == '0)
    |=> (count == $past(actPrd)));

  // R5: triangle turns downward at the period
  p_updown_turn_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !phaseLoad && cfg.mode == MODE_UPDOWN && dirUp
     && actPrd != '0 && count >= actPrd) |=> !dirUp);

  // R6: hold mode keeps the count
  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.mode == MODE_HOLD && !phaseLoad) |=> $stable(count));

  // R7: sync with phase enable loads the phase value
  p_phase_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.syncAny && cfg.phaseEn) |=> (count == $past(phaseVal)));

  // R12: max flag stays until cleared
  p_max_sticky_r12: assert property (@(posedge clk) disable iff (!rstN)
    (maxSeen && !strb.clrMax) |=> maxSeen);

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import tbase_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2,
  parameter int PRE_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              syncIn,
  input  logic [CNT_W-1:0]  cmpB,
  output logic [CNT_W-1:0]  count,
  output logic              dirUp,
  output logic              tickEn,
  output logic              ctrZero,
  output logic              ctrPeriod,
  output logic              syncOut,
  output logic              syncSeen,
  output logic              maxSeen
);

  tbCfg_t           cfg;
  tbStrobe_t        strb;
  logic [CNT_W-1:0] phaseVal;
  logic [CNT_W-1:0] prdShadow;

  tbase_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .PRE_W(PRE_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .syncIn(syncIn), .cfg(cfg), .strb(strb), .phaseVal(phaseVal),
    .prdShadow(prdShadow)
  );

  tbase_count #(.CNT_W(CNT_W)) count_i (
    .clk(clk), .rstN(rstN), .cfg(cfg), .strb(strb), .phaseVal(phaseVal),
    .prdShadow(prdShadow), .cmpB(cmpB), .count(count), .dirUp(dirUp),
    .ctrZero(ctrZero), .ctrPeriod(ctrPeriod), .syncOut(syncOut),
    .syncSeen(syncSeen), .maxSeen(maxSeen)
  );

  assign tickEn = strb.tick;

endmodule

// File: tb/pwm_timebase_tb_top.sv
`timescale 1ns/1ps
module pwm_timebase_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        syncIn = 1'b0;
  logic [15:0] cmpB = '0;
  logic [15:0] count;
  logic        dirUp, tickEn, ctrZero, ctrPeriod, syncOut, syncSeen, maxSeen;

  int nChk = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pwm_timebase dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .syncIn(syncIn), .cmpB(cmpB), .count(count), .dirUp(dirUp),
    .tickEn(tickEn), .ctrZero(ctrZero), .ctrPeriod(ctrPeriod),
    .syncOut(syncOut), .syncSeen(syncSeen), .maxSeen(maxSeen)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ctlWord(input int mode, input int phEn, input int direct,
                                          input int sel, input int sw, input int hs,
                                          input int cd, input int pdir);
    logic [15:0] w;
    w = '0;
    w[1:0]   = 2'(mode);
    w[2]     = 1'(phEn);
    w[3]     = 1'(direct);
    w[5:4]   = 2'(sel);
    w[6]     = 1'(sw);
    w[9:7]   = 3'(hs);
    w[12:10] = 3'(cd);
    w[13]    = 1'(pdir);
    return w;
  endfunction

  task automatic wr(input int addr, input logic [15:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 2'(addr); wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitTick();
    int k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!tickEn && k < 5000);
  endtask

  task automatic pulseSync();
    @(negedge clk); syncIn = 1'b1;
    @(negedge clk); syncIn = 1'b0;
  endtask

  // follow tick samples and compare each with the successor of the previous one
  task automatic runSeq(input int mode, input int p, input int nTicks, input string req);
    int prevC = 0, prevD = 0, got = 0, eC, eD;
    bit have = 1'b0;
    while (got < nTicks) begin
      @(negedge clk);
      if (!tickEn) begin
        chk(!ctrZero && !ctrPeriod, "R11 strobe without tick", {ctrZero, ctrPeriod}, 0);
      end else begin
        if (have) begin
          eD = prevD;
          if (mode == 0) begin
            eC = (prevC >= p) ? 0 : prevC + 1; eD = 1;
          end else if (mode == 1) begin
            eC = (prevC == 0) ? p : prevC - 1; eD = 0;
          end else begin
            if (prevD == 1) begin
              if (prevC >= p) begin eC = prevC - 1; eD = 0; end
              else eC = prevC + 1;
            end else begin
              if (prevC == 0) begin eC = 1; eD = 1; end
              else eC = prevC - 1;
            end
          end
          chk(count == 16'(eC), req, count, eC);
          chk(dirUp == 1'(eD), {req, " direction"}, dirUp, eD);
          chk(ctrZero == (count == 0) && ctrPeriod == (count == 16'(p)),
              "R11 strobes", {ctrZero, ctrPeriod}, {(count == 0), (count == 16'(p))});
          got++;
        end
        prevC = count; prevD = dirUp; have = 1'b1;
      end
    end
  endtask

  task automatic catchCount(input int target);
    int k = 0;
    do begin
      waitTick();
      k++;
    end while (count != 16'(target) && k < 40);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    int exp, n, bad, c;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(count == 0, "R1 count", count, 0);
    chk(dirUp == 1, "R1 direction", dirUp, 1);
    chk(!syncSeen && !maxSeen, "R1 flags", {syncSeen, maxSeen}, 0);
    chk(syncOut == 0, "R1 syncOut", syncOut, 0);

    // R2 divider sweep
    for (int cd = 0; cd < 8; cd++) begin
      for (int hs = 0; hs < 8; hs++) begin
        wr(0, ctlWord(0, 0, 1, 3, 0, hs, cd, 0));
        waitTick();
        n = 0;
        do begin @(negedge clk); n++; end while (!tickEn && n < 5000);
        exp = (1 << cd) * ((hs == 0) ? 1 : 2 * hs);
        chk(n == exp, "R2 tick spacing", n, exp);
      end
    end

    // R3 up mode, period 5, divide by 2
    wr(0, ctlWord(0, 0, 1, 3, 0, 0, 1, 0));
    wr(1, 16'd5);
    repeat (4) @(negedge clk);
    runSeq(0, 5, 20, "R3 up count");
    // R4 down mode
    wr(0, ctlWord(1, 0, 1, 3, 0, 0, 0, 0));
    repeat (4) @(negedge clk);
    runSeq(1, 5, 20, "R4 down count");
    // R5 up-down, period 4
    wr(0, ctlWord(2, 0, 1, 3, 0, 0, 0, 0));
    wr(1, 16'd4);
    repeat (4) @(negedge clk);
    runSeq(2, 4, 24, "R5 up-down count");

    // R6 hold
    wr(0, ctlWord(3, 0, 1, 3, 0, 0, 0, 0));
    repeat (2) @(negedge clk);
    c = count; bad = 0;
    repeat (20) begin @(negedge clk); if (count != 16'(c)) bad++; end
    chk(bad == 0 && count == 16'(c), "R6 hold", count, c);

    // R7 phase load with direction down
    wr(2, 16'd7);
    wr(0, ctlWord(2, 1, 1, 3, 0, 0, 7, 0));
    wr(1, 16'd10);
    waitTick();
    pulseSync();
    @(negedge clk);
    chk(count == 7, "R7 phase load", count, 7);
    chk(dirUp == 0, "R7 phase direction down", dirUp, 0);
    chk(syncSeen == 1, "R12 sync seen set", syncSeen, 1);
    waitTick(); @(negedge clk);
    chk(count == 6, "R7 count after load", count, 6);
    // R7 direction up
    wr(2, 16'd3);
    wr(0, ctlWord(2, 1, 1, 3, 0, 0, 7, 1));
    waitTick();
    pulseSync();
    @(negedge clk);
    chk(count == 3 && dirUp == 1, "R7 phase load up", count, 3);
    waitTick(); @(negedge clk);
    chk(count == 4, "R7 count after load up", count, 4);
    // R7 phase disabled: sync ignored
    wr(0, ctlWord(2, 0, 1, 3, 0, 0, 7, 0));
    waitTick(); @(negedge clk);
    c = count;
    pulseSync();
    repeat (2) @(negedge clk);
    chk(count == 16'(c), "R7 sync ignored without phase enable", count, c);

    // R8 software force, one shot
    wr(3, 16'd1);
    @(negedge clk);
    chk(syncSeen == 0, "R12 sync seen cleared", syncSeen, 0);
    wr(0, ctlWord(0, 1, 1, 3, 0, 0, 7, 0));
    wr(1, 16'd20);
    wr(2, 16'd9);
    waitTick(); @(negedge clk);
    wr(0, ctlWord(0, 1, 1, 3, 1, 0, 7, 0));
    @(negedge clk);
    chk(count == 9, "R8 force load", count, 9);
    chk(syncSeen == 0, "R12 force leaves sync seen", syncSeen, 0);
    waitTick(); @(negedge clk);
    chk(count == 10, "R8 force not retained", count, 10);

    // R9 sync-out sources, up mode period 5, divide by 2
    wr(0, ctlWord(0, 0, 1, 1, 0, 0, 1, 0));
    wr(1, 16'd5);
    repeat (4) @(negedge clk);
    bad = 0;
    repeat (30) begin @(negedge clk); if (syncOut != (tickEn && count == 0)) bad++; end
    chk(bad == 0, "R9 zero source", bad, 0);
    cmpB = 16'd3;
    wr(0, ctlWord(0, 0, 1, 2, 0, 0, 1, 0));
    bad = 0;
    repeat (30) begin @(negedge clk); if (syncOut != (tickEn && count == 3)) bad++; end
    chk(bad == 0, "R9 compare-B source", bad, 0);
    wr(0, ctlWord(0, 0, 1, 3, 0, 0, 1, 0));
    bad = 0;
    fork
      pulseSync();
      repeat (30) begin @(negedge clk); if (syncOut) bad++; end
    join
    chk(bad == 0, "R9 disabled source", bad, 0);
    wr(0, ctlWord(0, 0, 1, 0, 0, 0, 1, 0));
    @(negedge clk); syncIn = 1'b1;
    chk(syncOut == 0, "R9 pass before", syncOut, 0);
    @(negedge clk); syncIn = 1'b0;
    chk(syncOut == 1, "R9 pass delayed", syncOut, 1);
    @(negedge clk);
    chk(syncOut == 0, "R9 pass one clock", syncOut, 0);

    // R10 shadowed period write, promoted at zero
    wr(0, ctlWord(0, 0, 0, 3, 0, 0, 3, 0));
    catchCount(2);
    wr(1, 16'd8);
    for (int i = 0; i < 12; i++) begin
      exp = (i < 3) ? i + 3 : i - 3;
      waitTick();
      chk(count == 16'(exp), "R10 shadow promotion", count, exp);
    end
    // R10 direct period write
    wr(0, ctlWord(0, 0, 1, 3, 0, 0, 3, 0));
    catchCount(2);
    wr(1, 16'd3);
    for (int i = 0; i < 6; i++) begin
      exp = (i == 0) ? 3 : (i - 1) % 4;
      waitTick();
      chk(count == 16'(exp), "R10 direct write", count, exp);
    end

    // R12 max flag and clears
    wr(3, 16'd3);
    wr(0, ctlWord(3, 1, 1, 3, 0, 0, 0, 0));
    wr(2, 16'hFFFF);
    pulseSync();
    repeat (2) @(negedge clk);
    chk(count == 16'hFFFF, "R12 load max", count, 16'hFFFF);
    chk(maxSeen == 1 && syncSeen == 1, "R12 max flag set", {maxSeen, syncSeen}, 3);
    wr(2, 16'd0);
    pulseSync();
    repeat (2) @(negedge clk);
    chk(count == 0 && maxSeen == 1, "R12 max flag sticky", maxSeen, 1);
    wr(3, 16'd2);
    @(negedge clk);
    chk(maxSeen == 0 && syncSeen == 1, "R12 clear max only", {maxSeen, syncSeen}, 1);
    wr(3, 16'd1);
    @(negedge clk);
    chk(syncSeen == 0, "R12 clear sync seen", syncSeen, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule